// File: doc/BRIEF.md
# Outbound Configuration Cycle Initiator

This block lets a local processor start PCI configuration transactions through a small register window. The processor first writes the target configuration address into an address register. Each single 32-bit access to the data window then creates one bus transaction. Writes complete toward the processor as soon as they are queued. Reads stall the processor until the bus returns data. The data window stores nothing: read data always comes from the bus.

Three outbound queues sit between the processor port and the bus side. The transaction queue holds the latched address, the byte enables and the direction. The write queue holds write data paired with its transaction. The read queue carries returned read data back to the processor. A bus master that sits outside this block consumes queued transactions through a request/acknowledge pair and returns read completions on a valid strobe. It can flag a master-abort, which produces all-ones data and sets a sticky status bit.

The processor side is driven by a three-state machine:
- ST_IDLE decodes a request.
- ST_RD_WAIT waits for read data.
- ST_RESP presents a one-cycle ready pulse.

Its transitions are:
- accept: ST_IDLE to ST_RESP, for a register access, a queued write or a refused access.
- issue_read: ST_IDLE to ST_RD_WAIT, for a queued read.
- read_return: ST_RD_WAIT to ST_RESP, when the read queue is non-empty.
- release: ST_RESP to ST_IDLE, always.
- stall: ST_IDLE to ST_IDLE, when a queue is full.

Top module: `cfgi_top`

## Requirements
- R1: After reset, the address register (word offset 0) reads 0, the status register (word offset 2) reads 0, and the bus request is low.
- R2: A write to word offset 0 latches the full 32-bit configuration address. A later read of offset 0 returns it.
- R3: A non-burst write to the data window (word offset 1) queues one transaction. The bus side presents it with the latched address, the access byte enables unchanged, the write flag set to 1, and the written data on the bus write-data lines. The processor gets its ready pulse with the error flag at 0.
- R4: A non-burst read of the data window queues one transaction with the write flag at 0. The ready pulse is held back until the bus returns read data. The response data then equals the data the bus returned.
- R5: Any access with the burst indication high gets a ready pulse with the error flag at 1 and read data 0. It queues no bus transaction and changes no register.
- R6: When the transaction queue holds TQ_DEPTH entries, a further data-window access gets no ready pulse until the bus consumes an entry. The same holds for a write when the write queue is full.
- R7: A read completion flagged as master-abort returns 32'hFFFF_FFFF to the processor and sets status bit 0.
- R8: Status bit 0 is cleared by writing 1 to bit 0 of word offset 2. Writing 0 there leaves it unchanged.
- R9: An access to word offset 3 gets an error response with read data 0, and has no effect on any register or queue.
- R10: Queued transactions reach the bus in the order the processor issued them, each write carrying its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_addr | input | 2 | Word offset: 0 address reg, 1 data window, 2 status, 3 unmapped |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Processor write data |
| cpu_be | input | 4 | Processor byte enables |
| cpu_burst | input | 1 | Burst indication (always refused) |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Response read data, valid with ready |
| cpu_err | output | 1 | Error response, valid with ready |
| bus_req | output | 1 | A transaction is waiting at the queue head |
| bus_addr | output | 32 | Configuration address of head transaction |
| bus_be | output | 4 | Byte enables of head transaction |
| bus_write | output | 1 | Head transaction is a write |
| bus_wdata | output | 32 | Write data paired with head write transaction |
| bus_ack | input | 1 | Bus master consumes the head transaction |
| bus_rd_valid | input | 1 | Read completion strobe |
| bus_rd_data | input | 32 | Read completion data |
| bus_rd_abort | input | 1 | Read completion ended in master-abort |

## Verification
The bench builds the block with its default depths of four for all three queues. This lets five back-to-back writes, with the bus side idle, fill the transaction queue and drive the stall state. With the same depth, the release and the in-order draining of all five writes can be observed. The bus responder in the bench can be paused, so the held-back read response and the stall can both be seen at the ports before the bus is allowed to complete them.

// File: rtl/cfgi_pkg.sv
package cfgi_pkg;

    localparam int DW  = 32;
    localparam int BEW = DW / 8;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_RESP    = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [DW-1:0]  addr;
        logic [BEW-1:0] be;
        logic           write;
    } txn_t;

endpackage

// File: rtl/cfgi_fifo.sv
module cfgi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

endmodule

// File: rtl/cfgi_ctrl.sv
module cfgi_ctrl
    import cfgi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic [1:0]     cpu_addr,
    input  logic           cpu_we,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic [BEW-1:0] cpu_be,
    input  logic           cpu_burst,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_err,
    input  logic           tq_full,
    input  logic           wq_full,
    input  logic           rq_empty,
    input  logic [DW-1:0]  rq_head,
    input  logic           abort_evt,
    output logic           tq_push,
    output txn_t           tq_entry,
    output logic           wq_push,
    output logic           rq_pop,
    output logic           abort_sticky
);
    ctl_state_e state, nxt;
    reg_sel_e   sel;
    logic [DW-1:0] addr_q;
    logic       ld_addr, clr_abort;
    logic       rsp_load, rsp_e;
    logic [DW-1:0] rsp_d;
    logic [DW-1:0] rsp_data_q;
    logic       rsp_err_q;

    assign sel = reg_sel_e'(cpu_addr);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and per-cycle outputs
    always_comb begin
        nxt       = state;
        tq_push   = 1'b0;
        wq_push   = 1'b0;
        rq_pop    = 1'b0;
        ld_addr   = 1'b0;
        clr_abort = 1'b0;
        rsp_load  = 1'b0;
        rsp_e     = 1'b0;
        rsp_d     = '0;
        tq_entry.addr  = addr_q;
        tq_entry.be    = cpu_be;
        tq_entry.write = cpu_we;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_burst) begin
                        rsp_load = 1'b1;
                        rsp_e    = 1'b1;
                        nxt      = ST_RESP;
                    end else begin
                        unique case (sel)
                            SEL_ADDR: begin
                                ld_addr  = cpu_we;
                                rsp_load = 1'b1;
                                rsp_d    = cpu_we ? '0 : addr_q;
                                nxt      = ST_RESP;
                            end
                            SEL_DATA: begin
                                if (cpu_we) begin
                                    if (!tq_full && !wq_full) begin
                                        tq_push  = 1'b1;
                                        wq_push  = 1'b1;
                                        rsp_load = 1'b1;
                                        nxt      = ST_RESP;
                                    end
                                end else if (!tq_full) begin
                                    tq_push = 1'b1;
                                    nxt     = ST_RD_WAIT;
                                end
                            end
                            SEL_STAT: begin
                                clr_abort = cpu_we && cpu_wdata[0];
                                rsp_load  = 1'b1;
                                rsp_d     = cpu_we ? '0 : {{(DW-1){1'b0}}, abort_sticky};
                                nxt       = ST_RESP;
                            end
                            default: begin
                                rsp_load = 1'b1;
                                rsp_e    = 1'b1;
                                nxt      = ST_RESP;
                            end
                        endcase
                    end
                end
            end
            ST_RD_WAIT: begin
                if (!rq_empty) begin
                    rq_pop   = 1'b1;
                    rsp_load = 1'b1;
                    rsp_d    = rq_head;
                    nxt      = ST_RESP;
                end
            end
            ST_RESP: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Held registers: address, response, sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            rsp_data_q   <= '0;
            rsp_err_q    <= 1'b0;
            abort_sticky <= 1'b0;
        end else begin
            if (ld_addr) begin
                addr_q <= cpu_wdata;
            end
            if (rsp_load) begin
                rsp_data_q <= rsp_d;
                rsp_err_q  <= rsp_e;
            end
            if (abort_evt) begin
                abort_sticky <= 1'b1;
            end else if (clr_abort) begin
                abort_sticky <= 1'b0;
            end
        end
    end

    assign cpu_ready = (state == ST_RESP);
    assign cpu_rdata = cpu_ready ? rsp_data_q : '0;
    assign cpu_err   = cpu_ready && rsp_err_q;

endmodule

// File: rtl/cfgi_top.sv
module cfgi_top
    import cfgi_pkg::*;
#(
    parameter int TQ_DEPTH = 4,
    parameter int WQ_DEPTH = 4,
    parameter int RQ_DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic [1:0]     cpu_addr,
    input  logic           cpu_we,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic [BEW-1:0] cpu_be,
    input  logic           cpu_burst,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_err,
    output logic           bus_req,
    output logic [DW-1:0]  bus_addr,
    output logic [BEW-1:0] bus_be,
    output logic           bus_write,
    output logic [DW-1:0]  bus_wdata,
    input  logic           bus_ack,
    input  logic           bus_rd_valid,
    input  logic [DW-1:0]  bus_rd_data,
    input  logic           bus_rd_abort
);
    localparam int TW = $bits(txn_t);

    logic    tq_push, tq_full, tq_empty, tq_pop;
    txn_t    tq_entry, tq_head;
    logic    wq_push, wq_full, wq_empty, wq_pop;
    logic    rq_full, rq_empty, rq_pop;
    logic [DW-1:0] rq_head, rq_din;
    logic    abort_sticky;

    cfgi_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_addr     (cpu_addr),
        .cpu_we       (cpu_we),
        .cpu_wdata    (cpu_wdata),
        .cpu_be       (cpu_be),
        .cpu_burst    (cpu_burst),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .cpu_err      (cpu_err),
        .tq_full      (tq_full),
        .wq_full      (wq_full),
        .rq_empty     (rq_empty),
        .rq_head      (rq_head),
        .abort_evt    (bus_rd_valid && bus_rd_abort),
        .tq_push      (tq_push),
        .tq_entry     (tq_entry),
        .wq_push      (wq_push),
        .rq_pop       (rq_pop),
        .abort_sticky (abort_sticky)
    );

    assign tq_pop = bus_ack && !tq_empty;
    assign wq_pop = tq_pop && tq_head.write;

    cfgi_fifo #(.W(TW), .DEPTH(TQ_DEPTH)) u_tq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tq_push),
        .din   (tq_entry),
        .pop   (tq_pop),
        .dout  (tq_head),
        .full  (tq_full),
        .empty (tq_empty)
    );

    cfgi_fifo #(.W(DW), .DEPTH(WQ_DEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wq_push),
        .din   (cpu_wdata),
        .pop   (wq_pop),
        .dout  (bus_wdata),
        .full  (wq_full),
        .empty (wq_empty)
    );

    assign rq_din = bus_rd_abort ? '1 : bus_rd_data;

    cfgi_fifo #(.W(DW), .DEPTH(RQ_DEPTH)) u_rq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bus_rd_valid),
        .din   (rq_din),
        .pop   (rq_pop),
        .dout  (rq_head),
        .full  (rq_full),
        .empty (rq_empty)
    );

    assign bus_req   = !tq_empty;
    assign bus_addr  = tq_head.addr;
    assign bus_be    = tq_head.be;
    assign bus_write = tq_head.write;

endmodule

// File: rtl/cfgi_chk.sv
module cfgi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_burst,
    input logic        cpu_ready,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic        bus_rd_valid,
    input logic        bus_rd_abort,
    input logic        tq_push,
    input logic        tq_full,
    input logic        wq_push,
    input logic        wq_full,
    input logic        wq_empty,
    input logic        rq_full,
    input logic        abort_sticky
);
    AST_BURST_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_burst |-> !tq_push);  // R5
    AST_TQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tq_full |-> !tq_push);  // R6
    AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wq_full |-> !wq_push);  // R6
    AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rq_full |-> !bus_rd_valid);  // R4
    AST_WRITE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_write |-> !wq_empty);  // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);  // R4
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_valid && bus_rd_abort |=> abort_sticky);  // R7
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr));  // R10
endmodule

bind cfgi_top cfgi_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_burst    (cpu_burst),
    .cpu_ready    (cpu_ready),
    .bus_req      (bus_req),
    .bus_ack      (bus_ack),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_rd_valid (bus_rd_valid),
    .bus_rd_abort (bus_rd_abort),
    .tq_push      (tq_push),
    .tq_full      (tq_full),
    .wq_push      (wq_push),
    .wq_full      (wq_full),
    .wq_empty     (wq_empty),
    .rq_full      (rq_full),
    .abort_sticky (abort_sticky)
);

// File: tb/cfgi_top_tb.sv
module cfgi_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_burst = 1'b0;
    logic        cpu_ready, cpu_err;
    logic [31:0] cpu_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic        bus_rd_valid = 1'b0;
    logic [31:0] bus_rd_data = '0;
    logic        bus_rd_abort = 1'b0;

    int total = 0;
    int bad = 0;
    bit auto_bus = 1'b0;
    int nlog = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [3:0]  log_be [16];
    logic        log_wr [16];

    always #2.5 clk = ~clk;

    cfgi_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_burst(cpu_burst), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .cpu_err(cpu_err), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rd_valid(bus_rd_valid),
        .bus_rd_data(bus_rd_data), .bus_rd_abort(bus_rd_abort)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus-side model: logs each transaction, acks it, answers reads
    initial begin
        forever begin
            @(negedge clk);
            if (auto_bus && bus_req && nlog < 16) begin
                log_addr[nlog] = bus_addr;
                log_data[nlog] = bus_wdata;
                log_be[nlog]   = bus_be;
                log_wr[nlog]   = bus_write;
                nlog++;
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                if (!log_wr[nlog-1]) begin
                    repeat (3) @(negedge clk);
                    bus_rd_valid = 1'b1;
                    bus_rd_abort = log_addr[nlog-1][31];
                    bus_rd_data  = log_addr[nlog-1] ^ 32'h5A5A_0000;
                    @(negedge clk);
                    bus_rd_valid = 1'b0;
                    bus_rd_abort = 1'b0;
                end
            end
        end
    end

    task automatic access(input logic [1:0] off, input logic we,
                          input logic [31:0] wd, input logic [3:0] be,
                          input logic burst,
                          output logic [31:0] rd, output logic err);
        int n = 0;
        @(negedge clk);
        cpu_addr = off; cpu_we = we; cpu_wdata = wd; cpu_be = be;
        cpu_burst = burst; cpu_req = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 1000);
        if (!cpu_ready) begin
            total++; bad++;
            $display("FAIL access timeout actual=0 expected=1");
        end
        rd = cpu_rdata; err = cpu_err;
        cpu_req = 1'b0; cpu_burst = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  off;
        logic        we;
        logic [31:0] wd;
        logic        burst;
        logic [31:0] exp_rd;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 1'b0, 32'h0,          1'b0, 32'h0,          1'b0}, // R1 addr reset
        '{2'd2, 1'b0, 32'h0,          1'b0, 32'h0,          1'b0}, // R1 status reset
        '{2'd0, 1'b1, 32'h0001_0804,  1'b0, 32'h0,          1'b0}, // R2 write
        '{2'd0, 1'b0, 32'h0,          1'b0, 32'h0001_0804,  1'b0}, // R2 readback
        '{2'd0, 1'b1, 32'h0000_FFFF,  1'b1, 32'h0,          1'b1}, // R5 burst refused
        '{2'd0, 1'b0, 32'h0,          1'b0, 32'h0001_0804,  1'b0}, // R5 unchanged
        '{2'd3, 1'b1, 32'h1234_5678,  1'b0, 32'h0,          1'b1}, // R9 unmapped write
        '{2'd3, 1'b0, 32'h0,          1'b0, 32'h0,          1'b1}, // R9 unmapped read
        '{2'd0, 1'b0, 32'h0,          1'b0, 32'h0001_0804,  1'b0}  // R9 no effect
    };

    initial begin
        int n = 0;
        while (n < 100000) begin
            @(posedge clk);
            n++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic err;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus_req after reset", {31'b0, bus_req}, 32'h0);
        check("R1 ready after reset", {31'b0, cpu_ready}, 32'h0);
        auto_bus = 1'b1;

        for (int i = 0; i < 9; i++) begin
            access(VECS[i].off, VECS[i].we, VECS[i].wd, 4'hF, VECS[i].burst, rd, err);
            check($sformatf("vector %0d rdata", i), rd, VECS[i].exp_rd);
            check($sformatf("vector %0d err", i), {31'b0, err}, {31'b0, VECS[i].exp_err});
        end
        check("R5 R9 no bus traffic", nlog, 0);

        // R3: configuration write
        access(2'd0, 1'b1, 32'h0002_0010, 4'hF, 1'b0, rd, err);
        access(2'd1, 1'b1, 32'hDEAD_BEEF, 4'b0011, 1'b0, rd, err);
        check("R3 write err", {31'b0, err}, 32'h0);
        repeat (4) @(negedge clk);
        check("R3 txn count", nlog, 1);
        check("R3 bus addr", log_addr[0], 32'h0002_0010);
        check("R3 bus be", {28'b0, log_be[0]}, 32'h3);
        check("R3 bus write", {31'b0, log_wr[0]}, 32'h1);
        check("R3 bus wdata", log_data[0], 32'hDEAD_BEEF);

        // R5: burst on the data window queues nothing
        n0 = nlog;
        access(2'd1, 1'b1, 32'h1111_1111, 4'hF, 1'b1, rd, err);
        check("R5 data burst err", {31'b0, err}, 32'h1);
        repeat (5) @(negedge clk);
        check("R5 data burst no txn", nlog, n0);

        // R4: read held until bus returns data
        auto_bus = 1'b0;
        access(2'd0, 1'b1, 32'h0003_0014, 4'hF, 1'b0, rd, err);
        @(negedge clk);
        cpu_addr = 2'd1; cpu_we = 1'b0; cpu_be = 4'hF; cpu_burst = 1'b0; cpu_req = 1'b1;
        repeat (6) @(negedge clk);
        check("R4 ready held", {31'b0, cpu_ready}, 32'h0);
        check("R4 bus read queued", {30'b0, bus_req, bus_write}, 32'h2);
        check("R4 bus read addr", bus_addr, 32'h0003_0014);
        auto_bus = 1'b1;
        n0 = 0;
        while (!cpu_ready && n0 < 100) begin @(negedge clk); n0++; end
        check("R4 read data", cpu_rdata, 32'h0003_0014 ^ 32'h5A5A_0000);
        check("R4 read err", {31'b0, cpu_err}, 32'h0);
        cpu_req = 1'b0;

        // R7: master-abort
        access(2'd0, 1'b1, 32'h8000_0020, 4'hF, 1'b0, rd, err);
        access(2'd1, 1'b0, 32'h0, 4'hF, 1'b0, rd, err);
        check("R7 abort data", rd, 32'hFFFF_FFFF);
        access(2'd2, 1'b0, 32'h0, 4'hF, 1'b0, rd, err);
        check("R7 sticky set", rd, 32'h1);

        // R8: write-one-to-clear
        access(2'd2, 1'b1, 32'h0, 4'hF, 1'b0, rd, err);
        access(2'd2, 1'b0, 32'h0, 4'hF, 1'b0, rd, err);
        check("R8 write zero keeps", rd, 32'h1);
        access(2'd2, 1'b1, 32'h1, 4'hF, 1'b0, rd, err);
        access(2'd2, 1'b0, 32'h0, 4'hF, 1'b0, rd, err);
        check("R8 write one clears", rd, 32'h0);

        // R6 and R10: stall on a full transaction queue, then in-order drain
        repeat (4) @(negedge clk);
        auto_bus = 1'b0;
        n0 = nlog;
        access(2'd0, 1'b1, 32'h0000_0100, 4'hF, 1'b0, rd, err);
        for (int i = 0; i < 4; i++) begin
            access(2'd1, 1'b1, 32'hA000_0000 + i, 4'hF, 1'b0, rd, err);
        end
        @(negedge clk);
        cpu_addr = 2'd1; cpu_we = 1'b1; cpu_wdata = 32'hA000_0004; cpu_be = 4'hF;
        cpu_burst = 1'b0; cpu_req = 1'b1;
        repeat (8) @(negedge clk);
        check("R6 stalled while full", {31'b0, cpu_ready}, 32'h0);
        check("R6 head write data", bus_wdata, 32'hA000_0000);
        auto_bus = 1'b1;
        begin
            int w = 0;
            while (!cpu_ready && w < 100) begin @(negedge clk); w++; end
        end
        check("R6 released", {31'b0, cpu_ready}, 32'h1);
        cpu_req = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 txn count", nlog - n0, 5);
        for (int i = 0; i < 5; i++) begin
            check($sformatf("R10 order data %0d", i), log_data[n0+i], 32'hA000_0000 + i);
            check($sformatf("R10 order addr %0d", i), log_addr[n0+i], 32'h0000_0100);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule